// File: doc/BRIEF.md
# Serial Peripheral Master with Sequenced Transfer Modes

This block is a serial peripheral master for one slave. Software fills a transmit FIFO through a small register port and reads received frames from a receive FIFO through the same port. The controller drives clock, data-out and an active-low select line by itself. It asserts select when a transfer begins and releases it when the transfer ends. The end of a transfer depends on the chosen mode: either the transmit FIFO runs dry, or a programmed number of frames has been received.

There are four modes. Full duplex stores every frame it receives. Send-only discards everything on the input line. Receive-only clocks in a fixed number of frames. Command-read is meant for serial memories: it shifts out the queued command and dummy frames, then keeps clocking and captures a programmed number of read frames, with select held low for the whole operation. The frame length is programmable from 4 to 16 bits. Each frame takes one FIFO entry, and received frames are zero-extended. Sticky flags record a lost receive frame, a read from the empty receive FIFO and a write to the full transmit FIFO.

Register map on `reg_addr`:
- 0 is control. Bits [1:0] select the mode: 0 full duplex, 1 send-only, 2 receive-only, 3 command-read. Bits [5:2] hold the frame length minus one. Bit 8 is enable. Writing 1 to bit 9 clears all sticky flags.
- 1 is the clock half-period minus one.
- 2 is the receive count.
- 3 is data. A write pushes a frame into the transmit FIFO. A read returns the head of the receive FIFO and pops it.

Top module: `spi_xfer_master`

## Requirements
- R1: After reset, select is high, SCLK and MOSI are low, busy is low, both FIFOs are empty with level 0, and no sticky flag is set.
- R2: In mode 0, a transfer starts when enable is set and the transmit FIFO holds data. Each frame is shifted out MSB first, with MISO sampled on the rising SCLK edge and MOSI changing on the falling edge. Every received frame is pushed into the receive FIFO.
- R3: In mode 1, frames are shifted out as in mode 0, but received bits are discarded and the receive FIFO stays empty.
- R4: Mode 2 starts on a control write that sets enable and selects mode 2, provided the receive count is non-zero. It clocks exactly that many frames with MOSI low and stores each received frame.
- R5: Mode 3 shifts out every queued transmit frame, storing nothing. It then clocks exactly the receive-count number of frames with MOSI low and stores them, all inside a single select assertion.
- R6: Select is asserted once per transfer and busy stays high while it is low. In modes 0 and 1, select is released after the frame during which the transmit FIFO was found empty.
- R7: Frame length is the control field plus one, between 4 and 16 bits. Received frames are zero-extended in their FIFO entry.
- R8: SCLK idles low. Its period is 2·(divider+1) system clock cycles.
- R9: A frame that completes while the receive FIFO is full is dropped and sets the sticky receive-overflow flag. Frames already stored are kept. A control write with bit 9 set clears the flag.
- R10: Reading data while the receive FIFO is empty sets the sticky underflow flag. Writing data while the transmit FIFO is full drops the frame and sets the sticky transmit-overflow flag.
- R11: While busy, writes to the receive-count, divider and mode/size/enable fields are ignored.
- R12: Both FIFOs are 8 entries deep and report empty, full and level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive FIFO at address 3) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of the strobe |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select |
| busy | output | 1 | Transfer in progress |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| tx_level | output | 4 | Transmit FIFO occupancy |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| rx_level | output | 4 | Receive FIFO occupancy |
| rx_overflow | output | 1 | Sticky: received frame lost |
| rx_underflow | output | 1 | Sticky: read of empty receive FIFO |
| tx_overflow | output | 1 | Sticky: write to full transmit FIFO |

## Verification
The bench targets the point where select is released. It counts SCLK rising edges per select assertion, so a design that stops one frame early or late, or that drops select between the command and read phases, shows a wrong bit count or a second assertion. It compares the read-phase frames against a bit-exact slave pattern at the right offset; a design that stored command-phase frames in mode 3 would return shifted data. It overfills the receive FIFO and the transmit FIFO, and it rewrites the receive count during a transfer. A design that overwrote old entries, dropped the sticky flags, or honoured the late count would give wrong frames, flags or lengths.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

   typedef enum logic [1:0] {
      XM_DUPLEX  = 2'd0,
      XM_SEND    = 2'd1,
      XM_RECV    = 2'd2,
      XM_CMDREAD = 2'd3
   } xfer_mode_e;

   localparam logic [1:0] RA_CTRL    = 2'd0;
   localparam logic [1:0] RA_CLKDIV  = 2'd1;
   localparam logic [1:0] RA_RDCOUNT = 2'd2;
   localparam logic [1:0] RA_DATA    = 2'd3;

   localparam int CTRL_SIZE_LSB = 2;
   localparam int CTRL_EN_BIT   = 8;
   localparam int CTRL_CLR_BIT  = 9;

endpackage

// File: rtl/spi_xfer_fifo.sv
module spi_xfer_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [W-1:0]                 wdata,
   input  logic                         pop,
   output logic [W-1:0]                 rdata,
   output logic                         empty,
   output logic                         full,
   output logic [$clog2(DEPTH+1)-1:0]   level
);
   localparam int AW = $clog2(DEPTH);
   localparam int LW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q, wp_nx, rp_nx;
   logic [LW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign full    = (cnt_q == LW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign level   = cnt_q;
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rp_q];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign wp_nx = wp_q + AW'(1);
         assign rp_nx = rp_q + AW'(1);
      end else begin : g_cmp_wrap
         assign wp_nx = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
         assign rp_nx = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wp_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_nx;
         if (do_pop)  rp_q <= rp_nx;
         if (do_push && !do_pop)      cnt_q <= cnt_q + LW'(1);
         else if (do_pop && !do_push) cnt_q <= cnt_q - LW'(1);
      end
   end

   // R12
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LW'(DEPTH));

   // R12
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> $stable(cnt_q));

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
   import spi_xfer_pkg::*;
#(
   parameter int FRAME_W = 16,
   parameter int DIV_W   = 8,
   parameter int CNT_W   = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          go,
   input  logic [1:0]                    cfg_mode,
   input  logic [$clog2(FRAME_W)-1:0]    cfg_fsz_m1,
   input  logic [DIV_W-1:0]              cfg_div,
   input  logic [CNT_W-1:0]              cfg_rxcnt,
   input  logic                          tx_empty,
   input  logic [FRAME_W-1:0]            tx_data,
   output logic                          tx_pop,
   output logic                          rx_push,
   output logic [FRAME_W-1:0]            rx_data,
   output logic                          busy,
   output logic                          sclk,
   output logic                          mosi,
   output logic                          cs_n,
   input  logic                          miso
);
   localparam int SZ_W = $clog2(FRAME_W);

   typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_e;

   eng_state_e         state_q;
   logic               sclk_q, cs_n_q, read_ph_q;
   logic [DIV_W-1:0]   tmr_q;
   logic [SZ_W-1:0]    bit_q;
   logic [FRAME_W-1:0] txsh_q, rxsh_q, fmask;
   logic [CNT_W-1:0]   rcnt_q;
   logic [CNT_W:0]     rnext;

   logic running, start_ok, tick, rise, fall, last;
   logic reads_done, capture;
   logic nxt_pop, nxt_end, nxt_read;

   assign running    = (state_q == ENG_RUN);
   assign start_ok   = !running && go;
   assign tick       = running && (tmr_q == cfg_div);
   assign rise       = tick && !sclk_q;
   assign fall       = tick && sclk_q;
   assign last       = fall && (bit_q == '0);
   assign rnext      = {1'b0, rcnt_q} + (CNT_W+1)'(1);
   assign reads_done = (rnext == {1'b0, cfg_rxcnt});
   assign capture    = (cfg_mode == XM_DUPLEX) || read_ph_q;

   // next-frame decision, evaluated at the last falling edge of a frame
   always_comb begin
      nxt_pop  = 1'b0;
      nxt_end  = 1'b0;
      nxt_read = read_ph_q;
      unique case (cfg_mode)
         XM_DUPLEX, XM_SEND: begin
            if (tx_empty) nxt_end = 1'b1;
            else          nxt_pop = 1'b1;
         end
         XM_RECV: nxt_end = reads_done;
         default: begin
            if (read_ph_q)               nxt_end  = reads_done;
            else if (!tx_empty)          nxt_pop  = 1'b1;
            else if (cfg_rxcnt == '0)    nxt_end  = 1'b1;
            else                         nxt_read = 1'b1;
         end
      endcase
   end

   always_comb begin
      for (int i = 0; i < FRAME_W; i++) fmask[i] = (i <= int'(cfg_fsz_m1));
   end

   assign tx_pop  = (start_ok && (cfg_mode != XM_RECV)) || (last && nxt_pop);
   assign rx_push = last && capture;
   assign rx_data = rxsh_q & fmask;
   assign busy    = running;
   assign sclk    = sclk_q;
   assign cs_n    = cs_n_q;
   assign mosi    = running && txsh_q[cfg_fsz_m1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ENG_IDLE;
         sclk_q    <= 1'b0;
         cs_n_q    <= 1'b1;
         read_ph_q <= 1'b0;
         tmr_q     <= '0;
         bit_q     <= '0;
         txsh_q    <= '0;
         rxsh_q    <= '0;
         rcnt_q    <= '0;
      end else if (start_ok) begin
         state_q   <= ENG_RUN;
         cs_n_q    <= 1'b0;
         sclk_q    <= 1'b0;
         tmr_q     <= '0;
         bit_q     <= cfg_fsz_m1;
         rcnt_q    <= '0;
         read_ph_q <= (cfg_mode == XM_RECV);
         txsh_q    <= (cfg_mode == XM_RECV) ? '0 : tx_data;
      end else if (running) begin
         tmr_q <= tick ? '0 : tmr_q + DIV_W'(1);
         if (rise) begin
            sclk_q <= 1'b1;
            rxsh_q <= {rxsh_q[FRAME_W-2:0], miso};
         end
         if (fall) begin
            sclk_q <= 1'b0;
            if (bit_q != '0) begin
               bit_q  <= bit_q - SZ_W'(1);
               txsh_q <= txsh_q << 1;
            end else begin
               if (read_ph_q) rcnt_q <= rnext[CNT_W-1:0];
               if (nxt_end) begin
                  state_q   <= ENG_IDLE;
                  cs_n_q    <= 1'b1;
                  read_ph_q <= 1'b0;
               end else begin
                  bit_q     <= cfg_fsz_m1;
                  read_ph_q <= nxt_read;
                  txsh_q    <= nxt_pop ? tx_data : '0;
               end
            end
         end
      end
   end

   // R8
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // R6
   busy_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);

   // R3
   send_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == XM_SEND) |-> !rx_push);

   // R4
   read_mosi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && read_ph_q) |-> !mosi);

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
   import spi_xfer_pkg::*;
#(
   parameter int REG_W      = 16,
   parameter int FRAME_W    = 16,
   parameter int FIFO_DEPTH = 8,
   parameter int DIV_W      = 8,
   parameter int CNT_W      = 16
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               reg_wr,
   input  logic                               reg_rd,
   input  logic [1:0]                         reg_addr,
   input  logic [REG_W-1:0]                   reg_wdata,
   output logic [REG_W-1:0]                   reg_rdata,
   output logic                               sclk,
   output logic                               mosi,
   input  logic                               miso,
   output logic                               cs_n,
   output logic                               busy,
   output logic                               tx_empty,
   output logic                               tx_full,
   output logic [$clog2(FIFO_DEPTH+1)-1:0]    tx_level,
   output logic                               rx_empty,
   output logic                               rx_full,
   output logic [$clog2(FIFO_DEPTH+1)-1:0]    rx_level,
   output logic                               rx_overflow,
   output logic                               rx_underflow,
   output logic                               tx_overflow
);
   localparam int SZ_W = $clog2(FRAME_W);

   generate
      if (FRAME_W < 4 || FRAME_W > REG_W || FRAME_W > 16) begin : g_bad_frame
         $error("spi_xfer_master: FRAME_W out of range");
      end
      if (DIV_W > REG_W || CNT_W > REG_W) begin : g_bad_reg
         $error("spi_xfer_master: DIV_W or CNT_W wider than register port");
      end
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("spi_xfer_master: FIFO_DEPTH must be at least 2");
      end
      if (REG_W <= CTRL_CLR_BIT) begin : g_bad_regw
         $error("spi_xfer_master: REG_W too narrow for control fields");
      end
   endgenerate

   logic [1:0]         ctrl_mode_q;
   logic [SZ_W-1:0]    ctrl_fsz_q;
   logic               ctrl_en_q;
   logic [DIV_W-1:0]   div_q;
   logic [CNT_W-1:0]   rxcnt_q;
   logic               kick_q;
   logic               rx_ovf_q, rx_udf_q, tx_ovf_q;

   logic               cfg_ok, ctrl_wr, clr_wr, data_wr, data_rd;
   logic [3:0]         fsz_field;
   logic               tx_pop, rx_push, go;
   logic [FRAME_W-1:0] tx_head, rx_head, rx_frame;

   assign cfg_ok    = reg_wr && !busy;
   assign ctrl_wr   = reg_wr && (reg_addr == RA_CTRL);
   assign clr_wr    = ctrl_wr && reg_wdata[CTRL_CLR_BIT];
   assign data_wr   = reg_wr && (reg_addr == RA_DATA);
   assign data_rd   = reg_rd && (reg_addr == RA_DATA);
   assign fsz_field = reg_wdata[CTRL_SIZE_LSB +: 4];

   assign go = (ctrl_en_q && (ctrl_mode_q != XM_RECV) && !tx_empty) || kick_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_mode_q <= XM_DUPLEX;
         ctrl_fsz_q  <= SZ_W'(7);
         ctrl_en_q   <= 1'b0;
         div_q       <= '0;
         rxcnt_q     <= '0;
         kick_q      <= 1'b0;
      end else begin
         kick_q <= cfg_ok && ctrl_wr && reg_wdata[CTRL_EN_BIT]
                   && (reg_wdata[1:0] == XM_RECV) && (rxcnt_q != '0);
         if (cfg_ok) begin
            unique case (reg_addr)
               RA_CTRL: begin
                  ctrl_mode_q <= reg_wdata[1:0];
                  ctrl_en_q   <= reg_wdata[CTRL_EN_BIT];
                  if (int'(fsz_field) > FRAME_W - 1) ctrl_fsz_q <= SZ_W'(FRAME_W - 1);
                  else                               ctrl_fsz_q <= SZ_W'(fsz_field);
               end
               RA_CLKDIV:  div_q   <= reg_wdata[DIV_W-1:0];
               RA_RDCOUNT: rxcnt_q <= reg_wdata[CNT_W-1:0];
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_ovf_q <= 1'b0;
         rx_udf_q <= 1'b0;
         tx_ovf_q <= 1'b0;
      end else begin
         if (rx_push && rx_full)   rx_ovf_q <= 1'b1;
         else if (clr_wr)          rx_ovf_q <= 1'b0;
         if (data_rd && rx_empty)  rx_udf_q <= 1'b1;
         else if (clr_wr)          rx_udf_q <= 1'b0;
         if (data_wr && tx_full)   tx_ovf_q <= 1'b1;
         else if (clr_wr)          tx_ovf_q <= 1'b0;
      end
   end

   assign rx_overflow  = rx_ovf_q;
   assign rx_underflow = rx_udf_q;
   assign tx_overflow  = tx_ovf_q;

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_CTRL: begin
            reg_rdata[1:0]                    = ctrl_mode_q;
            reg_rdata[CTRL_SIZE_LSB +: SZ_W]  = ctrl_fsz_q;
            reg_rdata[CTRL_EN_BIT]            = ctrl_en_q;
         end
         RA_CLKDIV:  reg_rdata[DIV_W-1:0]   = div_q;
         RA_RDCOUNT: reg_rdata[CNT_W-1:0]   = rxcnt_q;
         default:    reg_rdata[FRAME_W-1:0] = rx_head;
      endcase
   end

   spi_xfer_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (data_wr),
      .wdata (reg_wdata[FRAME_W-1:0]),
      .pop   (tx_pop),
      .rdata (tx_head),
      .empty (tx_empty),
      .full  (tx_full),
      .level (tx_level)
   );

   spi_xfer_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_push),
      .wdata (rx_frame),
      .pop   (data_rd),
      .rdata (rx_head),
      .empty (rx_empty),
      .full  (rx_full),
      .level (rx_level)
   );

   spi_xfer_engine #(.FRAME_W(FRAME_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .cfg_mode   (ctrl_mode_q),
      .cfg_fsz_m1 (ctrl_fsz_q),
      .cfg_div    (div_q),
      .cfg_rxcnt  (rxcnt_q),
      .tx_empty   (tx_empty),
      .tx_data    (tx_head),
      .tx_pop     (tx_pop),
      .rx_push    (rx_push),
      .rx_data    (rx_frame),
      .busy       (busy),
      .sclk       (sclk),
      .mosi       (mosi),
      .cs_n       (cs_n),
      .miso       (miso)
   );

   // R11
   rdcount_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr && reg_addr == RA_RDCOUNT) |=> $stable(rxcnt_q));

   // R11
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(ctrl_mode_q));

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ovf_q && !clr_wr) |=> rx_ovf_q);

   // R10
   txq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && tx_full) |=> tx_overflow);

endmodule

// File: tb/spi_xfer_master_test.sv
`timescale 1ns/1ps
module spi_xfer_master_test;
   import spi_xfer_pkg::*;

   localparam logic [63:0] SLV_PAT = 64'hC3A5_9617_E24B_0FD8;

   // {mode, size-1, ntx, nread, div, pad, tx0, tx1}
   localparam logic [63:0] VECS [6] = '{
      {2'd0, 4'd7,  2'd2, 8'd0, 8'd1, 8'd0, 16'h00A5, 16'h003C},
      {2'd1, 4'd11, 2'd2, 8'd0, 8'd0, 8'd0, 16'h0ABC, 16'h0123},
      {2'd2, 4'd7,  2'd0, 8'd3, 8'd2, 8'd0, 16'h0000, 16'h0000},
      {2'd3, 4'd7,  2'd2, 8'd3, 8'd1, 8'd0, 16'h0003, 16'h005A},
      {2'd0, 4'd15, 2'd1, 8'd0, 8'd3, 8'd0, 16'hF00D, 16'h0000},
      {2'd3, 4'd3,  2'd1, 8'd2, 8'd0, 8'd0, 16'h0009, 16'h0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        sclk, mosi, miso, cs_n, busy;
   logic        tx_empty, tx_full, rx_empty, rx_full;
   logic [3:0]  tx_level, rx_level;
   logic        rx_overflow, rx_underflow, tx_overflow;

   int errors = 0, checks = 0, cycles = 0;
   int nbits = 0, ncs = 0, cs_start = 0;
   logic mosi_log [1024];
   time  rise_t   [1024];

   always #5 clk = ~clk;

   spi_xfer_master uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .busy(busy),
      .tx_empty(tx_empty), .tx_full(tx_full), .tx_level(tx_level),
      .rx_empty(rx_empty), .rx_full(rx_full), .rx_level(rx_level),
      .rx_overflow(rx_overflow), .rx_underflow(rx_underflow),
      .tx_overflow(tx_overflow)
   );

   // slave model: bit k after select falls is SLV_PAT[63 - k%64]
   assign miso = cs_n ? 1'b0 : SLV_PAT[63 - ((nbits - cs_start) % 64)];

   always @(negedge cs_n) begin
      ncs++;
      cs_start = nbits;
   end

   always @(posedge sclk) begin
      if (!cs_n) begin
         mosi_log[nbits] = mosi;
         rise_t[nbits]   = $time;
         nbits++;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         checks++;
         $display("FAIL R6 watchdog: cycles=%0d expected below 150000", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   function automatic int exp_bits(int off, int f);
      int v = 0;
      for (int b = 0; b < f; b++) v = (v << 1) | int'(SLV_PAT[63 - ((off + b) % 64)]);
      return v;
   endfunction

   function automatic logic [15:0] ctrlw(int m, int fm1, bit en, bit clr);
      return 16'(m) | 16'(fm1 << 2) | (16'(en) << 8) | (16'(clr) << 9);
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output int val);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 val = int'(reg_rdata);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_idle();
      repeat (4) @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   initial begin
      int val;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 cs_n", int'(cs_n), 1);
      chk("R1 sclk", int'(sclk), 0);
      chk("R1 mosi", int'(mosi), 0);
      chk("R1 busy", int'(busy), 0);
      chk("R1 tx_empty", int'(tx_empty), 1);
      chk("R1 rx_empty", int'(rx_empty), 1);
      chk("R1 levels", int'(tx_level) + int'(rx_level), 0);
      chk("R1 flags", int'(rx_overflow) + int'(rx_underflow) + int'(tx_overflow), 0);

      // table-driven mode runs
      for (int v = 0; v < 6; v++) begin
         logic [63:0] e;
         int mode, f, ntx, nrd, dv, total, nrx, rxoff, b0, c0, mism;
         logic [15:0] txw [2];
         string tag;
         e = VECS[v];
         mode = int'(e[63:62]); f = int'(e[61:58]) + 1; ntx = int'(e[57:56]);
         nrd = int'(e[55:48]); dv = int'(e[47:40]);
         txw[0] = e[31:16]; txw[1] = e[15:0];
         tag = (mode == 0) ? "R2" : (mode == 1) ? "R3" : (mode == 2) ? "R4" : "R5";
         total = ntx + ((mode >= 2) ? nrd : 0);
         nrx   = (mode == 0) ? ntx : (mode == 1) ? 0 : nrd;
         rxoff = (mode == 3) ? ntx * f : 0;

         wr(RA_CLKDIV, 16'(dv));
         wr(RA_RDCOUNT, 16'(nrd));
         wr(RA_CTRL, ctrlw(mode, f - 1, 1'b0, 1'b0));
         for (int i = 0; i < ntx; i++) wr(RA_DATA, txw[i]);
         b0 = nbits; c0 = ncs;
         wr(RA_CTRL, ctrlw(mode, f - 1, 1'b1, 1'b0));
         wait_idle();

         chk({"R6 bits clocked ", tag}, nbits - b0, f * total);
         chk({"R6 single select ", tag}, ncs - c0, 1);
         mism = 0;
         for (int i = 0; i < total * f; i++) begin
            int fr, bt;
            logic expb;
            fr = i / f; bt = i % f;
            expb = (fr < ntx) ? txw[fr][f - 1 - bt] : 1'b0;
            if (mosi_log[b0 + i] !== expb) mism++;
         end
         chk({tag, " mosi stream"}, mism, 0);
         chk("R8 sclk period", int'(rise_t[b0 + 1] - rise_t[b0]), 20 * (dv + 1));
         chk({tag, " R7 rx level"}, int'(rx_level), nrx);
         for (int j = 0; j < nrx; j++) begin
            rd(RA_DATA, val);
            chk({tag, " R7 rx frame"}, val, exp_bits(rxoff + j * f, f));
         end
         chk("R12 rx drained", int'(rx_empty), 1);
         wr(RA_CTRL, ctrlw(mode, f - 1, 1'b0, 1'b0));
      end

      // R9 receive overflow, R10 underflow
      begin
         int b0;
         wr(RA_CLKDIV, 16'd0);
         wr(RA_RDCOUNT, 16'd10);
         b0 = nbits;
         wr(RA_CTRL, ctrlw(2, 7, 1'b1, 1'b0));
         wait_idle();
         chk("R4 ten frames", nbits - b0, 80);
         chk("R12 rx level full", int'(rx_level), 8);
         chk("R12 rx_full", int'(rx_full), 1);
         chk("R9 overflow set", int'(rx_overflow), 1);
         for (int j = 0; j < 8; j++) begin
            rd(RA_DATA, val);
            if (j == 0 || j == 7) chk("R9 kept frame", val, exp_bits(j * 8, 8));
         end
         chk("R9 sticky after reads", int'(rx_overflow), 1);
         rd(RA_DATA, val);
         chk("R10 underflow set", int'(rx_underflow), 1);
         wr(RA_CTRL, ctrlw(2, 7, 1'b0, 1'b1));
         chk("R9 overflow cleared", int'(rx_overflow), 0);
         chk("R10 underflow cleared", int'(rx_underflow), 0);
      end

      // R10 transmit overflow, then drain in send-only mode
      begin
         int b0, c0, mism;
         wr(RA_CTRL, ctrlw(1, 7, 1'b0, 1'b0));
         for (int i = 0; i < 9; i++) wr(RA_DATA, 16'(i * 17));
         chk("R10 tx_overflow", int'(tx_overflow), 1);
         chk("R12 tx level", int'(tx_level), 8);
         chk("R12 tx_full", int'(tx_full), 1);
         b0 = nbits; c0 = ncs;
         wr(RA_CTRL, ctrlw(1, 7, 1'b1, 1'b0));
         wait_idle();
         chk("R6 eight frames then release", nbits - b0, 64);
         chk("R6 one select", ncs - c0, 1);
         mism = 0;
         for (int b = 0; b < 8; b++)
            if (mosi_log[b0 + 56 + b] !== 1'(((7 * 17) >> (7 - b)) & 1)) mism++;
         chk("R10 last kept frame", mism, 0);
         chk("R3 rx untouched", int'(rx_empty), 1);
         chk("R12 tx_empty", int'(tx_empty), 1);
         wr(RA_CTRL, ctrlw(1, 7, 1'b0, 1'b1));
      end

      // R11 receive count written while busy
      begin
         int b0;
         wr(RA_CLKDIV, 16'd7);
         wr(RA_RDCOUNT, 16'd2);
         b0 = nbits;
         wr(RA_CTRL, ctrlw(2, 7, 1'b1, 1'b0));
         while (!busy) @(negedge clk);
         wr(RA_RDCOUNT, 16'd5);
         wr(RA_CLKDIV, 16'd1);
         wait_idle();
         chk("R11 frames unchanged", nbits - b0, 16);
         rd(RA_RDCOUNT, val);
         chk("R11 count readback", val, 2);
         rd(RA_CLKDIV, val);
         chk("R11 divider readback", val, 7);
         chk("R11 period kept", int'(rise_t[b0 + 1] - rise_t[b0]), 160);
         for (int j = 0; j < 2; j++) begin
            rd(RA_DATA, val);
            chk("R4 rx frame", val, exp_bits(j * 8, 8));
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule